// File: doc/BRIEF.md
# Descriptor Ring Engine

This block keeps the transmit and receive buffer descriptors of a frame controller in on-chip storage. A host reads and writes that storage, and three control registers, over a simple word-wide register bus. The descriptor storage is a single table. A count register sets how many leading entries form the transmit ring, and every entry after them forms the receive ring. Each descriptor holds two 32-bit words: a status/length word and a buffer address word.

The engine keeps one pointer into each ring and presents the current descriptor to the frame side. On the transmit side it shows buffer address, length and the pad and CRC options while that descriptor is owned by hardware. When the frame side reports that a frame has finished, the engine writes the completion flags back, returns ownership to the host and moves on. On the receive side it reports whether an empty descriptor is waiting. When a frame arrives, the engine writes its length and flags into that descriptor. If no empty descriptor is waiting, it records a dropped frame instead.

Events are collected in a sticky interrupt source register, cleared by writing ones, and an interrupt mask gates them onto one interrupt line.

Top module: `bdr_engine`

## Requirements
- R1: After reset the following are all zero: the interrupt source register, the interrupt mask register, the transmit count register, both ring pointers, and every descriptor word. The irq, tx_avail and rx_ready outputs are low.
- R2: The register map is: byte offset 0x00 is the interrupt source, 0x04 is the interrupt mask, and 0x08 is the transmit count. Descriptor n has its status word at 0x400+8n and its address word at 0x404+8n. Read data appears on bus_rdata one clock after a read request.
- R3: A write to the transmit count stores the smaller of the written value and NUM_BD (0x80 by default). Descriptors 0 to count-1 form the transmit ring and the descriptors from count upward form the receive ring.
- R4: Status word bit 15 is ready, bit 14 is interrupt enable, bit 13 is wrap, bit 12 is pad and bit 11 is CRC; bits 31:16 hold the length. While the current transmit descriptor has bit 15 set, tx_avail is high and tx_buf_addr, tx_len, tx_pad_en and tx_crc_en show its fields. On tx_done the engine clears bit 15 and replaces bits 8:0 with tx_flags; bits 31:9 other than bit 15 are kept.
- R5: tx_flags bit 0 is carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, and bit 8 underrun. When the completed descriptor has bit 14 set, source bit 1 (transmit error) is set if any of bits 0, 2, 3 or 8 is set; otherwise source bit 0 (transmit done) is set.
- R6: When rx_arrive occurs and the current receive descriptor has bit 15 (empty) set, the engine writes that descriptor's status word as follows: bits 31:16 take rx_len and bits 8:0 take rx_flags. Bits 14:13 keep their old values, and bit 15 and bits 12:9 are cleared.
- R7: rx_flags bit 0 is late collision, bit 1 CRC error, bit 2 short, bit 3 too long, bit 4 dribble nibble, bit 5 invalid symbol, bit 6 overrun, bit 7 missed, and bit 8 control frame. When the stored descriptor has bit 14 set, the source bit is chosen in this order: bit 8 set gives source bit 6; otherwise any of bits 0-3 or 5-7 gives source bit 3; otherwise source bit 2 is set.
- R8: If rx_arrive occurs while the current receive descriptor is not empty, or while the receive ring has no entries, source bit 4 (busy) is set whatever bit 14 holds. No descriptor changes and the receive pointer holds.
- R9: After a ring's current descriptor is completed, its pointer returns to the first entry of that ring if the descriptor has bit 13 set or is the last entry of its ring. Otherwise the pointer moves to the next entry.
- R10: A tx_done pulse while tx_avail is low changes no descriptor, no pointer and no source bit.
- R11: Writing the source register clears every bit written as 1. An event in the same cycle sets its bit anyway.
- R12: irq is high exactly when some source bit and its mask bit are both set.
- R13: Any write to the transmit count returns both ring pointers to the first entry of their rings.
- R14: A tx_ctrl_sent pulse sets source bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| tx_avail | output | 1 | Current transmit descriptor is owned by hardware |
| tx_buf_addr | output | 32 | Buffer address of current transmit descriptor |
| tx_len | output | 16 | Length of current transmit descriptor |
| tx_pad_en | output | 1 | Pad option of current transmit descriptor |
| tx_crc_en | output | 1 | CRC option of current transmit descriptor |
| tx_done | input | 1 | Frame finished strobe |
| tx_flags | input | 9 | Completion flags for the finished frame |
| tx_ctrl_sent | input | 1 | Control frame sent strobe |
| rx_ready | output | 1 | Current receive descriptor is empty |
| rx_buf_addr | output | 32 | Buffer address of current receive descriptor |
| rx_arrive | input | 1 | Frame arrived strobe |
| rx_len | input | 16 | Length of arrived frame |
| rx_flags | input | 9 | Status flags of arrived frame |
| irq | output | 1 | Masked interrupt |

## Verification
Transmit completions are driven with clean flags, with a late-collision flag, and while the descriptor is still owned by the host. These separate the done event, the error event and the ignore path. Receive frames are driven into an empty descriptor with and without the interrupt enable, with error flags, with the control-frame flag and into a full descriptor. These separate the three receive events, the silent store and the busy drop. Ring walks use an explicit wrap bit, a one-entry transmit ring and a count rewrite in the middle of a walk, which shows whether each pointer wrapped for the right reason. A source-clear write in the same cycle as an event tests the clear-versus-set priority.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int BD_READY = 15;
  localparam int BD_IE    = 14;
  localparam int BD_WRAP  = 13;
  localparam int BD_PAD   = 12;
  localparam int BD_CRC   = 11;
  localparam int FLAG_W   = 9;
  localparam int IRQ_W    = 7;

  // flag groups that count as errors
  localparam logic [FLAG_W-1:0] TX_ERR_FLAGS = 9'h10D;
  localparam logic [FLAG_W-1:0] RX_ERR_FLAGS = 9'h0EF;
  localparam int RX_CTRL_FLAG = 8;

  // transmit completion keeps everything except ownership and flags
  localparam logic [31:0] TX_KEEP = 32'hFFFF_7E00;
  localparam logic [31:0] RX_KEEP = 32'h0000_6000;

  // packed so that the vector bit index equals the source bit position
  typedef struct packed {
    logic rxc;
    logic txc;
    logic busy;
    logic rxe;
    logic rxf;
    logic txe;
    logic txf;
  } irq_evt_t;
endpackage

// File: rtl/bdr_desc_mem.sv
module bdr_desc_mem #(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic             host_word,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [IDX_W-1:0] tx_idx,
  output logic [31:0]      tx_stat,
  output logic [31:0]      tx_addr,
  input  logic             tx_we,
  input  logic [31:0]      tx_wstat,
  input  logic [IDX_W-1:0] rx_idx,
  output logic [31:0]      rx_stat,
  output logic [31:0]      rx_addr,
  input  logic             rx_we,
  input  logic [31:0]      rx_wstat
);
  logic [31:0] st_q [NUM_BD];
  logic [31:0] st_d [NUM_BD];
  logic [31:0] ad_q [NUM_BD];
  logic [NUM_BD-1:0] st_en;
  logic [NUM_BD-1:0] ad_en;

  // engine writes follow host writes so the engine wins a collision
  always_comb begin
    for (int i = 0; i < NUM_BD; i++) begin
      st_en[i] = 1'b0;
      st_d[i]  = st_q[i];
      ad_en[i] = host_we && host_word && (host_idx == IDX_W'(i));
      if (host_we && !host_word && (host_idx == IDX_W'(i))) begin
        st_en[i] = 1'b1;
        st_d[i]  = host_wdata;
      end
      if (tx_we && (tx_idx == IDX_W'(i))) begin
        st_en[i] = 1'b1;
        st_d[i]  = tx_wstat;
      end
      if (rx_we && (rx_idx == IDX_W'(i))) begin
        st_en[i] = 1'b1;
        st_d[i]  = rx_wstat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) begin
        st_q[i] <= '0;
        ad_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_BD; i++) begin
        if (st_en[i]) st_q[i] <= st_d[i];
        if (ad_en[i]) ad_q[i] <= host_wdata;
      end
    end
  end

  assign host_rdata = host_word ? ad_q[host_idx] : st_q[host_idx];
  assign tx_stat    = st_q[tx_idx];
  assign tx_addr    = ad_q[tx_idx];
  assign rx_stat    = st_q[rx_idx];
  assign rx_addr    = ad_q[rx_idx];
endmodule

// File: rtl/bdr_ring_ctrl.sv
module bdr_ring_ctrl
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clear,
  input  logic [CNT_W-1:0]  txcnt,
  input  logic              tx_done,
  input  logic [FLAG_W-1:0] tx_flags,
  input  logic              tx_ctrl_sent,
  input  logic [31:0]       tx_stat,
  input  logic              rx_arrive,
  input  logic [15:0]       rx_len,
  input  logic [FLAG_W-1:0] rx_flags,
  input  logic [31:0]       rx_stat,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [IDX_W-1:0]  rx_idx,
  output logic [IDX_W-1:0]  rx_ptr,
  output logic              tx_avail,
  output logic              rx_ready,
  output logic              tx_we,
  output logic [31:0]       tx_wstat,
  output logic              rx_we,
  output logic [31:0]       rx_wstat,
  output irq_evt_t          evt
);
  logic [IDX_W-1:0] tx_ptr_q, tx_ptr_d, rx_ptr_q, rx_ptr_d;
  logic tx_ptr_en, rx_ptr_en;
  logic tx_ring_on, rx_ring_on, tx_fire, rx_fire, rx_drop, tx_last, rx_last;
  logic tx_err, rx_err, rx_ctl;

  assign tx_ring_on = (txcnt != '0);
  assign rx_ring_on = (txcnt < CNT_W'(NUM_BD));
  assign tx_idx     = tx_ptr_q;
  assign rx_ptr     = rx_ptr_q;
  assign rx_idx     = txcnt[IDX_W-1:0] + rx_ptr_q;
  assign tx_avail   = tx_ring_on && tx_stat[BD_READY];
  assign rx_ready   = rx_ring_on && rx_stat[BD_READY];

  assign tx_fire = tx_done && tx_avail;
  assign rx_fire = rx_arrive && rx_ready;
  assign rx_drop = rx_arrive && !rx_ready;
  assign tx_last = tx_stat[BD_WRAP] || (CNT_W'(tx_ptr_q) == txcnt - CNT_W'(1));
  assign rx_last = rx_stat[BD_WRAP] || (rx_idx == IDX_W'(NUM_BD - 1));
  assign tx_err  = |(tx_flags & TX_ERR_FLAGS);
  assign rx_err  = |(rx_flags & RX_ERR_FLAGS);
  assign rx_ctl  = rx_flags[RX_CTRL_FLAG];

  assign tx_we    = tx_fire;
  assign tx_wstat = (tx_stat & TX_KEEP) | {{(32-FLAG_W){1'b0}}, tx_flags};
  assign rx_we    = rx_fire;
  assign rx_wstat = {rx_len, 16'h0000} | (rx_stat & RX_KEEP) | {{(32-FLAG_W){1'b0}}, rx_flags};

  always_comb begin
    evt      = '0;
    evt.txf  = tx_fire && tx_stat[BD_IE] && !tx_err;
    evt.txe  = tx_fire && tx_stat[BD_IE] && tx_err;
    evt.rxc  = rx_fire && rx_stat[BD_IE] && rx_ctl;
    evt.rxe  = rx_fire && rx_stat[BD_IE] && !rx_ctl && rx_err;
    evt.rxf  = rx_fire && rx_stat[BD_IE] && !rx_ctl && !rx_err;
    evt.busy = rx_drop;
    evt.txc  = tx_ctrl_sent;
  end

  always_comb begin
    tx_ptr_en = ptr_clear || tx_fire;
    rx_ptr_en = ptr_clear || rx_fire;
    tx_ptr_d  = tx_ptr_q;
    rx_ptr_d  = rx_ptr_q;
    if (ptr_clear) begin
      tx_ptr_d = '0;
      rx_ptr_d = '0;
    end else begin
      if (tx_fire) tx_ptr_d = tx_last ? '0 : tx_ptr_q + IDX_W'(1);
      if (rx_fire) rx_ptr_d = rx_last ? '0 : rx_ptr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ptr_q <= '0;
      rx_ptr_q <= '0;
    end else begin
      if (tx_ptr_en) tx_ptr_q <= tx_ptr_d;
      if (rx_ptr_en) rx_ptr_q <= rx_ptr_d;
    end
  end
endmodule

// File: rtl/bdr_regs.sv
module bdr_regs
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_src,
  input  logic             wr_mask,
  input  logic             wr_cnt,
  input  logic [31:0]      wdata,
  input  irq_evt_t         evt,
  output logic [IRQ_W-1:0] irq_src,
  output logic [IRQ_W-1:0] irq_mask,
  output logic [CNT_W-1:0] txcnt,
  output logic             ptr_clear,
  output logic             irq
);
  logic [IRQ_W-1:0] src_d, mask_d;
  logic [CNT_W-1:0] cnt_d;
  logic src_en;

  always_comb begin
    src_en = wr_src || (|evt);
    src_d  = (irq_src & ~(wr_src ? wdata[IRQ_W-1:0] : '0)) | evt;
    mask_d = wdata[IRQ_W-1:0];
    cnt_d  = (wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_src  <= '0;
      irq_mask <= '0;
      txcnt    <= '0;
    end else begin
      if (src_en)  irq_src  <= src_d;
      if (wr_mask) irq_mask <= mask_d;
      if (wr_cnt)  txcnt    <= cnt_d;
    end
  end

  assign ptr_clear = wr_cnt;
  assign irq       = |(irq_src & irq_mask);
endmodule

// File: rtl/bdr_engine.sv
module bdr_engine
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_avail,
  output logic [31:0]       tx_buf_addr,
  output logic [15:0]       tx_len,
  output logic              tx_pad_en,
  output logic              tx_crc_en,
  input  logic              tx_done,
  input  logic [8:0]        tx_flags,
  input  logic              tx_ctrl_sent,
  output logic              rx_ready,
  output logic [31:0]       rx_buf_addr,
  input  logic              rx_arrive,
  input  logic [15:0]       rx_len,
  input  logic [8:0]        rx_flags,
  output logic              irq
);
  localparam int IDX_W = (NUM_BD > 1) ? $clog2(NUM_BD) : 1;
  localparam int CNT_W = $clog2(NUM_BD + 1);
  localparam logic [ADDR_W-1:0] DESC_BASE = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_SRC   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CNT   = ADDR_W'(8);

  logic              host_wr, host_rd, desc_hit;
  logic [ADDR_W-1:0] desc_num;
  logic [IDX_W-1:0]  host_idx, tx_idx, rx_idx, rx_ptr;
  logic [31:0]       host_rdata, tx_stat, tx_addr, rx_stat, rx_addr;
  logic [31:0]       tx_wstat, rx_wstat, rdata_d;
  logic              tx_we, rx_we, ptr_clear, tx_ie, rx_ie;
  logic [IRQ_W-1:0]  irq_src, irq_mask;
  logic [CNT_W-1:0]  txcnt;
  irq_evt_t          evt;

  assign host_wr  = bus_sel && bus_wr;
  assign host_rd  = bus_sel && !bus_wr;
  assign desc_num = (bus_addr - DESC_BASE) >> 3;
  assign desc_hit = (bus_addr >= DESC_BASE) && (desc_num < ADDR_W'(NUM_BD));
  assign host_idx = desc_num[IDX_W-1:0];

  bdr_regs #(.NUM_BD(NUM_BD), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_src    (host_wr && (bus_addr == OFS_SRC)),
    .wr_mask   (host_wr && (bus_addr == OFS_MASK)),
    .wr_cnt    (host_wr && (bus_addr == OFS_CNT)),
    .wdata     (bus_wdata),
    .evt       (evt),
    .irq_src   (irq_src),
    .irq_mask  (irq_mask),
    .txcnt     (txcnt),
    .ptr_clear (ptr_clear),
    .irq       (irq)
  );

  bdr_desc_mem #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_wr && desc_hit),
    .host_idx   (host_idx),
    .host_word  (bus_addr[2]),
    .host_wdata (bus_wdata),
    .host_rdata (host_rdata),
    .tx_idx     (tx_idx),
    .tx_stat    (tx_stat),
    .tx_addr    (tx_addr),
    .tx_we      (tx_we),
    .tx_wstat   (tx_wstat),
    .rx_idx     (rx_idx),
    .rx_stat    (rx_stat),
    .rx_addr    (rx_addr),
    .rx_we      (rx_we),
    .rx_wstat   (rx_wstat)
  );

  bdr_ring_ctrl #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_clear    (ptr_clear),
    .txcnt        (txcnt),
    .tx_done      (tx_done),
    .tx_flags     (tx_flags),
    .tx_ctrl_sent (tx_ctrl_sent),
    .tx_stat      (tx_stat),
    .rx_arrive    (rx_arrive),
    .rx_len       (rx_len),
    .rx_flags     (rx_flags),
    .rx_stat      (rx_stat),
    .tx_idx       (tx_idx),
    .rx_idx       (rx_idx),
    .rx_ptr       (rx_ptr),
    .tx_avail     (tx_avail),
    .rx_ready     (rx_ready),
    .tx_we        (tx_we),
    .tx_wstat     (tx_wstat),
    .rx_we        (rx_we),
    .rx_wstat     (rx_wstat),
    .evt          (evt)
  );

  assign tx_ie       = tx_stat[BD_IE];
  assign rx_ie       = rx_stat[BD_IE];
  assign tx_buf_addr = tx_addr;
  assign tx_len      = tx_stat[31:16];
  assign tx_pad_en   = tx_stat[BD_PAD];
  assign tx_crc_en   = tx_stat[BD_CRC];
  assign rx_buf_addr = rx_addr;

  always_comb begin
    rdata_d = '0;
    if (desc_hit)                  rdata_d = host_rdata;
    else if (bus_addr == OFS_SRC)  rdata_d = {{(32-IRQ_W){1'b0}}, irq_src};
    else if (bus_addr == OFS_MASK) rdata_d = {{(32-IRQ_W){1'b0}}, irq_mask};
    else if (bus_addr == OFS_CNT)  rdata_d = {{(32-CNT_W){1'b0}}, txcnt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (host_rd) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/bdr_engine_chk.sv
module bdr_engine_chk #(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_done,
  input logic             tx_avail,
  input logic             tx_ie,
  input logic             rx_arrive,
  input logic             rx_ready,
  input logic             rx_ie,
  input logic             ptr_clear,
  input logic [IDX_W-1:0] tx_idx,
  input logic [IDX_W-1:0] rx_ptr,
  input logic [CNT_W-1:0] txcnt,
  input logic [6:0]       irq_src,
  input logic [6:0]       irq_mask,
  input logic             irq
);
  AST_TXCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    txcnt <= CNT_W'(NUM_BD)); // R3

  AST_TX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && tx_avail && tx_ie |=> (irq_src[0] || irq_src[1])); // R5

  AST_RX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive && rx_ready && rx_ie |=> (irq_src[2] || irq_src[3] || irq_src[6])); // R7

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive && !rx_ready |=> irq_src[4]); // R8

  AST_BUSY_HOLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive && !rx_ready && !ptr_clear |=> $stable(rx_ptr)); // R8

  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_avail && !ptr_clear |=> $stable(tx_idx)); // R10

  AST_IRQ_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 7'd0) |-> !irq); // R12

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clear |=> (tx_idx == '0) && (rx_ptr == '0)); // R13
endmodule

bind bdr_engine bdr_engine_chk #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_done   (tx_done),
  .tx_avail  (tx_avail),
  .tx_ie     (tx_ie),
  .rx_arrive (rx_arrive),
  .rx_ready  (rx_ready),
  .rx_ie     (rx_ie),
  .ptr_clear (ptr_clear),
  .tx_idx    (tx_idx),
  .rx_ptr    (rx_ptr),
  .txcnt     (txcnt),
  .irq_src   (irq_src),
  .irq_mask  (irq_mask),
  .irq       (irq)
);

// File: tb/bdr_engine_tb.sv
`timescale 1ns/1ps
module bdr_engine_tb;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              tx_avail, tx_pad_en, tx_crc_en, tx_done, tx_ctrl_sent;
  logic [31:0]       tx_buf_addr, rx_buf_addr;
  logic [15:0]       tx_len, rx_len;
  logic [8:0]        tx_flags, rx_flags;
  logic              rx_ready, rx_arrive, irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [6:0]  exp_src = '0;

  always #10 clk = ~clk;

  bdr_engine #(.NUM_BD(128), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_avail(tx_avail), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_pad_en(tx_pad_en), .tx_crc_en(tx_crc_en), .tx_done(tx_done),
    .tx_flags(tx_flags), .tx_ctrl_sent(tx_ctrl_sent), .rx_ready(rx_ready),
    .rx_buf_addr(rx_buf_addr), .rx_arrive(rx_arrive), .rx_len(rx_len),
    .rx_flags(rx_flags), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: each read request pops one expected item
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_sel && !bus_wr) begin
        #2;
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL scoreboard: unexpected read, actual 0x%08h expected none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_expect(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_tx(input logic [8:0] f);
    @(negedge clk);
    tx_done = 1'b1; tx_flags = f;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic pulse_rx(input logic [15:0] l, input logic [8:0] f);
    @(negedge clk);
    rx_arrive = 1'b1; rx_len = l; rx_flags = f;
    @(negedge clk);
    rx_arrive = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_done = 1'b0; tx_flags = '0; tx_ctrl_sent = 1'b0;
    rx_arrive = 1'b0; rx_len = '0; rx_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_expect(12'h000, 32'h0, "R1 source");
    bus_expect(12'h004, 32'h0, "R1 mask");
    bus_expect(12'h008, 32'h0, "R1 count");
    bus_expect(12'h400, 32'h0, "R1 desc0 status");
    bus_expect(12'h404, 32'h0, "R1 desc0 addr");
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 tx_avail", 32'(tx_avail), 32'h0);
    check("R1 rx_ready", 32'(rx_ready), 32'h0);

    // R3 clamp; no receive entries means drop (R8)
    bus_write(12'h008, 32'h200);
    bus_expect(12'h008, 32'h80, "R3 count clamped");
    pulse_rx(16'h40, 9'h0);
    exp_src = exp_src | 7'h10;
    bus_expect(12'h000, 32'(exp_src), "R8 busy with empty rx ring");
    bus_write(12'h000, 32'h10);
    exp_src = exp_src & ~7'h10;
    bus_expect(12'h000, 32'(exp_src), "R11 write one clears");
    bus_write(12'h008, 32'd2);

    // R2 address word map
    bus_write(12'h42C, 32'hDEADBEEF);
    bus_expect(12'h42C, 32'hDEADBEEF, "R2 desc5 addr word");
    bus_expect(12'h428, 32'h0, "R2 desc5 status word separate");
    bus_write(12'h404, 32'h1000_0000);
    bus_write(12'h40C, 32'h1000_0800);

    // R4/R5 transmit
    bus_write(12'h400, 32'h0064_C800);
    bus_write(12'h408, 32'h003C_E000);
    @(negedge clk);
    check("R4 tx_avail", 32'(tx_avail), 32'h1);
    check("R4 tx_len", 32'(tx_len), 32'd100);
    check("R4 tx_buf_addr", tx_buf_addr, 32'h1000_0000);
    check("R4 crc/pad", {30'h0, tx_crc_en, tx_pad_en}, 32'h2);
    pulse_tx(9'h012);
    exp_src = exp_src | 7'h01;  // clean completion -> transmit done
    check("R12 irq masked", 32'(irq), 32'h0);
    check("R9 tx next len", 32'(tx_len), 32'd60);
    check("R9 tx next addr", tx_buf_addr, 32'h1000_0800);
    bus_expect(12'h400, 32'h0064_4812, "R4 desc0 written back");
    bus_expect(12'h000, 32'(exp_src), "R5 transmit done bit");
    bus_write(12'h004, 32'h7F);
    @(negedge clk);
    check("R12 irq unmasked", 32'(irq), 32'h1);
    bus_write(12'h000, 32'h01);
    exp_src = exp_src & ~7'h01;
    @(negedge clk);
    check("R12 irq after clear", 32'(irq), 32'h0);

    pulse_tx(9'h004);
    exp_src = exp_src | 7'h02;  // late collision -> transmit error
    bus_expect(12'h408, 32'h003C_6004, "R4 desc1 written back");
    bus_expect(12'h000, 32'(exp_src), "R5 transmit error bit");
    check("R9 wrap to desc0 (not ready)", 32'(tx_avail), 32'h0);
    pulse_tx(9'h001);
    bus_expect(12'h400, 32'h0064_4812, "R10 desc0 untouched");
    bus_expect(12'h000, 32'(exp_src), "R10 source untouched");
    bus_write(12'h000, 32'h7F);
    exp_src = '0;

    // R11/R14 set wins over clear in the same cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h20;
    tx_ctrl_sent = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tx_ctrl_sent = 1'b0;
    exp_src = 7'h20;
    bus_expect(12'h000, 32'(exp_src), "R14 R11 control sent, set wins");
    bus_write(12'h000, 32'h20);
    exp_src = '0;

    // R6/R7/R8/R9 receive
    bus_write(12'h410, 32'h0000_C000);
    bus_write(12'h414, 32'h2000_0000);
    bus_write(12'h418, 32'h0000_A000);
    @(negedge clk);
    check("R6 rx_ready", 32'(rx_ready), 32'h1);
    check("R6 rx_buf_addr", rx_buf_addr, 32'h2000_0000);
    pulse_rx(16'h40, 9'h000);
    exp_src = exp_src | 7'h04;
    bus_expect(12'h410, 32'h0040_4000, "R6 desc2 stored");
    bus_expect(12'h000, 32'(exp_src), "R7 receive frame bit");
    pulse_rx(16'h50, 9'h002);
    bus_expect(12'h418, 32'h0050_2002, "R6 desc3 stored, no enable");
    bus_expect(12'h000, 32'(exp_src), "R7 no event without enable");
    check("R9 rx wrapped to full desc2", 32'(rx_ready), 32'h0);
    pulse_rx(16'h60, 9'h000);
    exp_src = exp_src | 7'h10;
    bus_expect(12'h410, 32'h0040_4000, "R8 desc2 unchanged on drop");
    bus_expect(12'h000, 32'(exp_src), "R8 busy bit");
    bus_write(12'h000, 32'h7F);
    exp_src = '0;

    bus_write(12'h410, 32'h0000_C000);
    pulse_rx(16'h48, 9'h100);
    exp_src = exp_src | 7'h40;
    bus_expect(12'h410, 32'h0048_4100, "R8 pointer held, desc2 stored");
    bus_expect(12'h000, 32'(exp_src), "R7 control frame bit");
    bus_write(12'h418, 32'h0000_E000);
    pulse_rx(16'h44, 9'h041);
    exp_src = exp_src | 7'h08;
    bus_expect(12'h418, 32'h0044_6041, "R6 desc3 error frame");
    bus_expect(12'h000, 32'(exp_src), "R7 receive error bit");
    bus_write(12'h000, 32'h7F);
    exp_src = '0;

    // R13 count write rewinds both pointers
    bus_write(12'h410, 32'h0000_C000);
    pulse_rx(16'h30, 9'h000);             // rx pointer now at desc3
    bus_write(12'h400, 32'h0064_C800);
    pulse_tx(9'h000);                     // tx pointer now at desc1
    bus_write(12'h410, 32'h0000_C000);
    bus_write(12'h418, 32'h0000_A000);
    bus_write(12'h400, 32'h0022_C800);
    bus_write(12'h008, 32'd2);
    @(negedge clk);
    check("R13 tx pointer rewound", 32'(tx_len), 32'h22);
    pulse_rx(16'h70, 9'h000);
    bus_expect(12'h410, 32'h0070_4000, "R13 rx into desc2");
    bus_expect(12'h418, 32'h0000_A000, "R13 desc3 untouched");

    // R9 end of a one-entry transmit ring
    bus_write(12'h008, 32'd1);
    bus_write(12'h400, 32'h0010_C000);
    pulse_tx(9'h000);
    bus_expect(12'h400, 32'h0010_4000, "R4 single ring written back");
    bus_write(12'h400, 32'h0011_C000);
    @(negedge clk);
    check("R9 last entry wraps", {15'h0, tx_avail, tx_len}, 32'h0001_0011);

    while (exp_q.size() != 0) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule